// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a word-addressed down-counting timer for generating a regular system heartbeat. Software programs a 24-bit reload value, selects whether the count advances on every core clock cycle or only on cycles where an external reference tick enable is high, and turns it on. The counter steps down once per selected tick. The tick that finds it at zero is the expiry. On expiry the block raises a sticky event flag, optionally pulses an interrupt request for one cycle, and reloads. The time between expiries is therefore reload+1 ticks.

The flag is cleared as a side effect of reading the control/status word. Any write to the current-value word restarts the count from the reload value and also clears the flag. A reload value of zero turns the timer into a one-shot: the next expiry switches the enable bit off. Turning the enable bit off freezes the count, and turning it back on continues from the frozen value. Changing the clock-source bit reloads the counter at once. A read-only calibration word returns a fixed constant.

Reads return data in the same cycle from the current state. Read side effects and all writes take effect at the next rising clock edge.

Top module: `periodic_tick_timer`

## Requirements
- R1: After a synchronous active-low reset, the control, reload and current registers read zero and `tick_irq` is low.
- R2: Register map, byte offsets decoded from `bus_addr[3:2]` with `bus_addr[1:0]` zero: 0x0 control/status, 0x4 reload, 0x8 current, 0xC calibration. In control, bit 0 enables counting, bit 1 enables the interrupt, bit 2 selects the source (1 = core clock, 0 = `ref_tick`), and bit 16 is the flag. Only bits 2..0 are writable; every other bit, the flag included, is unchanged by a write and reads zero apart from the flag.
- R3: While enabled, the counter decreases by one on each selected tick: every cycle with the core-clock source, and only cycles with `ref_tick` high with the reference source.
- R4: A tick taken while the counter is zero is an expiry. It sets the flag and loads the reload value, so expiries are reload+1 ticks apart.
- R5: `tick_irq` is high for exactly the one cycle after an expiry edge, and only when the interrupt-enable bit was set at that expiry.
- R6: A read of the control word returns the flag and clears it at that edge; an expiry in the same cycle leaves the flag set.
- R7: A write of any data to the current word loads the reload value into the counter and clears the flag.
- R8: An expiry with a reload value of zero clears the enable bit, and counting stops.
- R9: The current word reads zero whenever the enable bit is clear.
- R10: The calibration word always reads 10000 (decimal), and writes to it have no effect.
- R11: A control write that changes the source bit loads the reload value into the counter.
- R12: Clearing the enable bit freezes the counter; setting it again without changing the source resumes from the frozen value, with no reload.
- R13: The reload and current values are 24 bits wide; upper write data bits are dropped and upper read bits are zero.
- R14: In a cycle with a write to the control or current word, no tick is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | Reference tick enable, one cycle per reference period |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tick_irq | output | 1 | One-cycle interrupt request on expiry |

## Verification
Every cycle, the assertions check that the counter steps down by exactly one on a tick and holds otherwise. They also check that a load takes the reload value, an expiry sets the flag, a zero reload turns the enable off, and the interrupt never lasts two cycles. The calibration and disabled-current read values are also checked every cycle. Only the bench scenarios can show the end-to-end periods at each source, the flag's life across reads, writes and expiries in one sequence, and the resume after a freeze. The same holds for the combined effect of random interleavings of register accesses with reference ticks.

// File: rtl/ptt_pkg.sv
// Shared constants and types for the periodic tick timer.
// Assumes word-aligned byte offsets on a 32-bit register bus.
package ptt_pkg;
    localparam int unsigned BIT_EN   = 0;
    localparam int unsigned BIT_IE   = 1;
    localparam int unsigned BIT_SRC  = 2;
    localparam int unsigned BIT_FLAG = 16;

    // Register selected by bus_addr[3:2]
    typedef enum logic [1:0] {
        REG_CTRL    = 2'd0,
        REG_RELOAD  = 2'd1,
        REG_CURRENT = 2'd2,
        REG_CALIB   = 2'd3
    } reg_sel_e;

    // Writable control bits, packed to match bit positions 2..0
    typedef struct packed {
        logic src;
        logic ie;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/ptt_step.sv
// Tick qualifier: decides in which cycles the counter may step.
// Assumes ref_tick is already synchronous to clk and one cycle wide.
module ptt_step (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic src_core,
    input  logic ref_tick,
    input  logic hold,
    output logic step
);
    // A step needs the enable, no competing bus write, and a tick of the chosen source
    always_comb begin
        step = en && !hold && (src_core || ref_tick);
    end

    // R3: with the reference source, no step without a reference tick
    a_r3_ref_gates_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_core && !ref_tick) |-> !step);
endmodule

// File: rtl/ptt_core.sv
// Down-counter datapath. Loads on request or on expiry, otherwise steps down.
// Assumes load and step are never both acted on (load has priority).
module ptt_core #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cur_val,
    output logic             expire
);
    logic [CNT_W-1:0] cur_q;

    // Expiry is a tick that finds the counter at zero
    always_comb begin
        expire = step && !load && (cur_q == '0);
    end

    // Counter register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (load || expire) begin
            cur_q <= reload_val;
        end else if (step) begin
            cur_q <= cur_q - CNT_W'(1);
        end
    end

    assign cur_val = cur_q;

    // R3: a non-expiring tick lowers the count by one
    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cur_q != '0) |=> cur_q == $past(cur_q) - CNT_W'(1));
    // R12: without tick or load the count holds
    a_r12_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(cur_q));
    // R11: a load request takes the reload value
    a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cur_q == $past(reload_val));
    // R4: expiry reloads
    a_r4_expire_reload: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> cur_q == $past(reload_val));
endmodule

// File: rtl/ptt_regs.sv
// Register file and bus decode: control bits, sticky flag, reload value,
// read-back mux and the registered interrupt pulse.
// Assumes single-cycle accesses; read data is combinational from state.
module ptt_regs
    import ptt_pkg::*;
#(
    parameter int unsigned CNT_W     = 24,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CAL_VALUE = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cur_val,
    input  logic              expire,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload_val,
    output logic              load,
    output logic              hold,
    output logic              irq
);
    localparam logic [DATA_W-1:0] CAL_WORD = DATA_W'(CAL_VALUE);

    ctrl_t            ctrl_q;
    logic             flag_q;
    logic [CNT_W-1:0] reload_q;
    logic             irq_q;
    logic             addr_ok;
    reg_sel_e         rsel;
    logic             wr_ctl, wr_rel, wr_cur, rd_ctl, rd_cur, rd_cal;
    ctrl_t            wctrl;

    // Address decode and access strobes
    always_comb begin
        addr_ok = ((bus_addr >> 4) == '0) && (bus_addr[1:0] == 2'b00);
        rsel    = reg_sel_e'(bus_addr[3:2]);
        wr_ctl  = bus_sel &&  bus_wr && addr_ok && rsel == REG_CTRL;
        wr_rel  = bus_sel &&  bus_wr && addr_ok && rsel == REG_RELOAD;
        wr_cur  = bus_sel &&  bus_wr && addr_ok && rsel == REG_CURRENT;
        rd_ctl  = bus_sel && !bus_wr && addr_ok && rsel == REG_CTRL;
        rd_cur  = bus_sel && !bus_wr && addr_ok && rsel == REG_CURRENT;
        rd_cal  = bus_sel && !bus_wr && addr_ok && rsel == REG_CALIB;
        wctrl   = ctrl_t'(bus_wdata[BIT_SRC:BIT_EN]);
    end

    // Counter requests: reload on current write or source change; writes hold the count
    always_comb begin
        load = wr_cur || (wr_ctl && (wctrl.src != ctrl_q.src));
        hold = wr_ctl || wr_cur;
    end

    // Control bits; a one-shot expiry clears the enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctl) begin
            ctrl_q <= wctrl;
        end else if (expire && reload_q == '0) begin
            ctrl_q.en <= 1'b0;
        end
    end

    // Sticky flag: current write clears, expiry sets, status read clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (wr_cur) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end else if (rd_ctl) begin
            flag_q <= 1'b0;
        end
    end

    // Reload value register, low bits only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (wr_rel) begin
            reload_q <= bus_wdata[CNT_W-1:0];
        end
    end

    // One-cycle interrupt pulse after an enabled expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= expire && ctrl_q.ie;
        end
    end

    // Read-back mux
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && addr_ok) begin
            unique case (rsel)
                REG_CTRL: begin
                    bus_rdata[BIT_SRC:BIT_EN] = ctrl_q;
                    bus_rdata[BIT_FLAG]       = flag_q;
                end
                REG_RELOAD:  bus_rdata[CNT_W-1:0] = reload_q;
                REG_CURRENT: bus_rdata[CNT_W-1:0] = ctrl_q.en ? cur_val : '0;
                REG_CALIB:   bus_rdata = CAL_WORD;
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign ctrl       = ctrl_q;
    assign reload_val = reload_q;
    assign irq        = irq_q;

    // R5: the request never stays high two cycles running
    a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    // R4: expiry leaves the flag set
    a_r4_flag_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag_q);
    // R7: current write clears the flag
    a_r7_cur_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cur |=> !flag_q);
    // R6: a status read without expiry leaves the flag clear
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctl && !expire) |=> !flag_q);
    // R2: control writes never alter the flag
    a_r2_flag_not_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> flag_q == $past(flag_q));
    // R8: zero reload at expiry switches counting off
    a_r8_zero_reload_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && reload_q == '0) |=> !ctrl_q.en);
    // R9: current reads zero while disabled
    a_r9_cur_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cur && !ctrl_q.en) |-> bus_rdata == '0);
    // R10: calibration word is constant
    a_r10_cal_const: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cal |-> bus_rdata == CAL_WORD);
endmodule

// File: rtl/periodic_tick_timer.sv
// Top of the periodic tick timer: register file, tick qualifier and counter.
// Assumes a synchronous active-low reset and a ref_tick synchronous to clk.
module periodic_tick_timer #(
    parameter int unsigned CNT_W     = 24,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CAL_VALUE = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tick_irq
);
    import ptt_pkg::*;

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] cur_val;
    logic             load, hold, step, expire;

    ptt_regs #(
        .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CAL_VALUE(CAL_VALUE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cur_val(cur_val), .expire(expire),
        .ctrl(ctrl), .reload_val(reload_val),
        .load(load), .hold(hold), .irq(tick_irq)
    );

    ptt_step u_step (
        .clk(clk), .rst_n(rst_n),
        .en(ctrl.en), .src_core(ctrl.src), .ref_tick(ref_tick),
        .hold(hold), .step(step)
    );

    ptt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .step(step), .load(load), .reload_val(reload_val),
        .cur_val(cur_val), .expire(expire)
    );

    // R14: a control or current write blocks the tick
    a_r14_write_blocks_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 4'h0) |-> !expire);
endmodule

// File: tb/test_periodic_tick_timer.sv
module test_periodic_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        tick_irq;

    int checks = 0;
    int fails  = 0;

    // Bench model state, built from the requirements
    logic        m_en = 0, m_ie = 0, m_src = 0, m_flag = 0, m_irq = 0;
    logic [23:0] m_rel = 0, m_cur = 0;

    always #5 clk = ~clk;

    periodic_tick_timer i_periodic_tick_timer (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_irq(tick_irq)
    );

    // Reference model update at each rising edge
    always @(posedge clk) begin
        logic wc, wcur, wrel, rc, stp, fire;
        if (!rst_n) begin
            m_en <= 0; m_ie <= 0; m_src <= 0; m_flag <= 0; m_irq <= 0;
            m_rel <= 0; m_cur <= 0;
        end else begin
            wc   = bus_sel &&  bus_wr && bus_addr == 4'h0;
            wrel = bus_sel &&  bus_wr && bus_addr == 4'h4;
            wcur = bus_sel &&  bus_wr && bus_addr == 4'h8;
            rc   = bus_sel && !bus_wr && bus_addr == 4'h0;
            stp  = m_en && (m_src || ref_tick) && !wc && !wcur;
            fire = stp && m_cur == 0;
            m_irq <= fire && m_ie;
            if (wcur) m_flag <= 0;
            else if (fire) m_flag <= 1;
            else if (rc) m_flag <= 0;
            if (wc) begin
                m_en <= bus_wdata[0]; m_ie <= bus_wdata[1]; m_src <= bus_wdata[2];
            end else if (fire && m_rel == 0) m_en <= 0;
            if (wcur || (wc && bus_wdata[2] != m_src) || fire) m_cur <= m_rel;
            else if (stp) m_cur <= m_cur - 24'd1;
            if (wrel) m_rel <= bus_wdata[23:0];
        end
    end

    function automatic logic [31:0] exp_rdata(input logic [3:0] a);
        case (a)
            4'h0: return {15'b0, m_flag, 13'b0, m_src, m_ie, m_en};
            4'h4: return {8'b0, m_rel};
            4'h8: return m_en ? {8'b0, m_cur} : 32'h0;
            4'hC: return 32'd10000;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive after the falling edge, then compare outputs
    task automatic cyc(input logic sel, input logic wr, input logic [3:0] a,
                       input logic [31:0] d, input logic rt, input string tag);
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d; ref_tick = rt;
        #1;
        check("R5 irq pulse", {31'b0, tick_irq}, {31'b0, m_irq});
        if (sel && !wr) check(tag, bus_rdata, exp_rdata(a));
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        cyc(1'b1, 1'b0, a, 32'h0, 1'b0, tag);
    endtask
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b1, a, d, 1'b0, "");
    endtask
    task automatic idle(input int n, input logic rt);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 4'h0, 32'h0, rt, "");
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R1..run actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd20240611);
        idle(3, 1'b0);
        rst_n = 1'b1;
        // R1: reset values
        rd(4'h0, "R1 ctrl reset");
        rd(4'h4, "R1 reload reset");
        rd(4'h8, "R1 current reset");
        // R13: upper reload bits dropped
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, "R13 reload width");
        // R2: only low bits of control written; upper bits read zero
        wr(4'h0, 32'hFFFE_FFF8);
        rd(4'h0, "R2 ctrl mask");
        // R7/R4/R5: period reload+1 at core clock, interrupt on
        wr(4'h4, 32'd3);
        wr(4'h0, 32'h7);
        wr(4'h8, 32'hDEAD_BEEF);
        rd(4'h8, "R7 current reloaded");
        for (int i = 0; i < 9; i++) rd(4'h8, "R4 count and reload");
        rd(4'h0, "R6 flag visible");
        rd(4'h0, "R6 flag cleared by read");
        idle(6, 1'b0);
        wr(4'h8, 32'h0);
        rd(4'h0, "R7 flag cleared by current write");
        // R12/R9: freeze and resume
        idle(2, 1'b0);
        wr(4'h0, 32'h6);
        rd(4'h8, "R9 current zero when off");
        idle(5, 1'b0);
        wr(4'h0, 32'h7);
        rd(4'h8, "R12 resume from frozen value");
        // R3/R11: reference source counts only with ref_tick
        wr(4'h4, 32'd5);
        wr(4'h0, 32'h3);
        rd(4'h8, "R11 source change reloads");
        idle(4, 1'b0);
        rd(4'h8, "R3 no ref tick, no count");
        idle(3, 1'b1);
        rd(4'h8, "R3 counts on ref tick");
        // R14: writes block a tick
        wr(4'h0, 32'h7);
        wr(4'h0, 32'h7);
        rd(4'h8, "R14 write holds count");
        // R8: zero reload one-shot
        wr(4'h4, 32'd0);
        idle(8, 1'b0);
        rd(4'h0, "R8 enable cleared");
        // R10: calibration constant, writes ignored
        wr(4'hC, 32'h0);
        rd(4'hC, "R10 calibration");
        // Random mix
        for (int n = 0; n < 4000; n++) begin
            int unsigned r;
            logic rt;
            logic [3:0] a;
            r  = $urandom % 100;
            rt = ($urandom % 3) == 0;
            a  = 4'(($urandom % 4) * 4);
            if (r < 35)
                cyc(1'b1, 1'b0, a, 32'h0, rt,
                    a == 4'h0 ? "R6 random ctrl" : a == 4'h4 ? "R13 random reload" :
                    a == 4'h8 ? "R3 random current" : "R10 random calib");
            else if (r < 45)
                cyc(1'b1, 1'b1, 4'h0, $urandom | (($urandom % 5 != 0) ? 32'h1 : 32'h0), rt, "");
            else if (r < 50)
                cyc(1'b1, 1'b1, 4'h4, ($urandom % 4 == 0) ? 32'h0 : $urandom % 7, rt, "");
            else if (r < 54)
                cyc(1'b1, 1'b1, 4'h8, $urandom, rt, "");
            else if (r < 56)
                cyc(1'b1, 1'b1, 4'hC, $urandom, rt, "");
            else
                cyc(1'b0, 1'b0, 4'h0, 32'h0, rt, "");
        end
        idle(2, 1'b0);
        summary();
        $finish;
    end
endmodule